// File: doc/BRIEF.md
# Resumable Whole Vector Register Mover

This block copies a whole group of 1, 2, 4 or 8 vector registers one element per cycle. It runs in one of three directions: register group to register group, memory to register group (whole load), or register group to memory (whole store). The element index at which copying begins is the block's own start-index register. Software can write that register. The engine advances it by one per element, so a transfer that stops on a memory fault can later be resumed from the same element. The vector length and vector type settings play no part: the length of a transfer depends only on the group size and the element size.

At start, the start index is split into a register offset within the group and an element offset within that register. Both come from shifts, because the number of elements per register is a power of two. The partial register is finished first, and the later registers are then copied whole. The element at flat index i of a memory transfer lives at `base + (i << esz)`. The state machine has three states. `ST_IDLE` accepts a command. It moves to `ST_RUN` when elements remain, to `ST_FIN` when the start index is already past the end, and stays in `ST_IDLE` (raising `illegal`) on a rejected command. `ST_RUN` moves one element per permitted cycle. It goes to `ST_FIN` after the last element and back to `ST_IDLE` on a fault. `ST_FIN` raises `done` for one cycle and returns to `ST_IDLE`.

Top module: `vreg_whole_mover`

## Requirements
- R1: A write on `csr_wr` while the block is idle and `start` is low loads the start index with the low log2(VLEN) bits of `csr_wdata`. All higher bits are dropped. A write at any other time is ignored.
- R2: The command field `op` is encoded as 00 for register move, 01 for whole load and 10 for whole store; 11 is reserved. The register group holds 2^`grp` registers. A command is rejected when `op` is 11, or when a register number it uses is not a multiple of the group size. A move checks both `src_reg` and `dst_reg`, a load checks `dst_reg`, and a store checks `src_reg`. On rejection, `illegal` pulses in the cycle after `start`, nothing is transferred, and the start index is unchanged.
- R3: A transfer covers ((VLEN/8) << `grp`) >> `esz` elements. A move always uses one-byte elements, whatever `esz` holds.
- R4: When the start index is at or beyond the transfer length, no element is transferred, the start index keeps its value, and `done` pulses in the cycle after `start`.
- R5: Otherwise, elements from the start index up to the last one are transferred in rising order. Destination elements below the start index are left untouched. The start index rises by one per element and reads zero when `done` is raised.
- R6: Element i sits in register `reg + (i >> (log2(VLEN/8) - esz))`, at element position i mod ((VLEN/8) >> `esz`) within that register. Its memory address is `mem_base + (i << esz)`.
- R7: A move transfers one element on every cycle. A load or store transfers one element on each cycle in which `mem_ready` is high. `done` is raised in the cycle after the last transfer, so an uninterrupted move of n elements shows `done` n+1 cycles after the `start` edge.
- R8: A memory response with `mem_fault` high ends the transfer. No write is made for the failing element, the start index holds that element's index, `fault` pulses in the next cycle, and `done` is not raised.
- R9: `done`, `fault` and `illegal` last one cycle each, and `done` is never high together with `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_wr | input | 1 | Write strobe for the start index |
| csr_wdata | input | XLEN | Value written to the start index |
| vstart | output | log2(VLEN) | Current start index |
| start | input | 1 | Command strobe |
| op | input | 2 | 00 move, 01 load, 10 store, 11 reserved |
| grp | input | 2 | log2 of the register group size |
| esz | input | 2 | log2 of the element size in bytes (load/store) |
| src_reg | input | 5 | First source register |
| dst_reg | input | 5 | First destination register |
| mem_base | input | XLEN | Memory base address |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Completion pulse |
| illegal | output | 1 | Rejected-command pulse |
| fault | output | 1 | Memory-fault pulse |
| rf_rd_reg | output | 5 | Register-file read register |
| rf_rd_idx | output | log2(VLEN/8) | Register-file read element position |
| rf_rdata | input | ELEN | Register-file read data (combinational) |
| rf_we | output | 1 | Register-file write enable |
| rf_wr_reg | output | 5 | Register-file write register |
| rf_wr_idx | output | log2(VLEN/8) | Register-file write element position |
| rf_wdata | output | ELEN | Register-file write data |
| rf_esz | output | 2 | Element size of both register-file accesses |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (store) |
| mem_addr | output | XLEN | Memory address |
| mem_wdata | output | ELEN | Memory write data |
| mem_rdata | input | ELEN | Memory read data, valid with `mem_ready` |
| mem_ready | input | 1 | Memory completes the current element |
| mem_fault | input | 1 | Memory reports a fault for the current element |

## Verification
A rejected command and a skipped transfer each answer one edge after the `start` edge. A move of n elements raises `done` n+1 edges after it. A fault shows `fault` one edge after the faulting response. Each scenario task raises `start` at a falling edge and counts rising edges until a pulse appears. It samples every output at the falling edge that follows, so the count can be compared exactly with those figures. Register-file and memory contents are compared against byte patterns computed in the bench only after the completion pulse has been seen. The element-order and fault-hold properties are checked cycle by cycle by the bound checker.

// File: rtl/vwm_pkg.sv
package vwm_pkg;
    typedef enum logic [1:0] {
        OP_MOVE  = 2'b00,
        OP_LOAD  = 2'b01,
        OP_STORE = 2'b10,
        OP_RSVD  = 2'b11
    } vwm_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_RUN  = 2'b01,
        ST_FIN  = 2'b10
    } vwm_state_e;
endpackage

// File: rtl/vwm_legal_chk.sv
module vwm_legal_chk
    import vwm_pkg::*;
#(
    parameter int REGW = 5
) (
    input  logic [1:0]      op,
    input  logic [1:0]      grp,
    input  logic [REGW-1:0] src_reg,
    input  logic [REGW-1:0] dst_reg,
    output logic            ok
);
    logic [REGW-1:0] grp_mask;
    logic            src_ok;
    logic            dst_ok;

    always_comb begin
        grp_mask = (REGW'(1) << grp) - REGW'(1);
        src_ok   = (src_reg & grp_mask) == '0;
        dst_ok   = (dst_reg & grp_mask) == '0;
        unique case (vwm_op_e'(op))
            OP_MOVE:  ok = src_ok && dst_ok;
            OP_LOAD:  ok = dst_ok;
            OP_STORE: ok = src_ok;
            default:  ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/vwm_locator.sv
module vwm_locator #(
    parameter int VLEN = 128,
    parameter int XLEN = 32,
    parameter int REGW = 5,
    localparam int LVB = $clog2(VLEN / 8),
    localparam int VSW = $clog2(VLEN)
) (
    input  logic [VSW-1:0]  flat_idx,
    input  logic [1:0]      esz,
    input  logic [REGW-1:0] reg_base,
    input  logic [XLEN-1:0] addr_base,
    output logic [REGW-1:0] reg_o,
    output logic [LVB-1:0]  pos_o,
    output logic [XLEN-1:0] addr_o
);
    int unsigned      shamt;
    logic [VSW-1:0]   pos_mask;

    always_comb begin
        shamt    = LVB - int'(esz);
        pos_mask = (VSW'(1) << shamt) - VSW'(1);
        reg_o    = reg_base + REGW'(flat_idx >> shamt);
        pos_o    = LVB'(flat_idx & pos_mask);
        addr_o   = addr_base + (XLEN'(flat_idx) << esz);
    end
endmodule

// File: rtl/vreg_whole_mover.sv
module vreg_whole_mover
    import vwm_pkg::*;
#(
    parameter int VLEN = 128,
    parameter int XLEN = 32,
    parameter int ELEN = 64,
    localparam int LVB = $clog2(VLEN / 8),
    localparam int VSW = $clog2(VLEN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            csr_wr,
    input  logic [XLEN-1:0] csr_wdata,
    output logic [VSW-1:0]  vstart,
    input  logic            start,
    input  logic [1:0]      op,
    input  logic [1:0]      grp,
    input  logic [1:0]      esz,
    input  logic [4:0]      src_reg,
    input  logic [4:0]      dst_reg,
    input  logic [XLEN-1:0] mem_base,
    output logic            busy,
    output logic            done,
    output logic            illegal,
    output logic            fault,
    output logic [4:0]      rf_rd_reg,
    output logic [LVB-1:0]  rf_rd_idx,
    input  logic [ELEN-1:0] rf_rdata,
    output logic            rf_we,
    output logic [4:0]      rf_wr_reg,
    output logic [LVB-1:0]  rf_wr_idx,
    output logic [ELEN-1:0] rf_wdata,
    output logic [1:0]      rf_esz,
    output logic            mem_req,
    output logic            mem_we,
    output logic [XLEN-1:0] mem_addr,
    output logic [ELEN-1:0] mem_wdata,
    input  logic [ELEN-1:0] mem_rdata,
    input  logic            mem_ready,
    input  logic            mem_fault
);
    localparam int VLENB = VLEN / 8;
    localparam int TW    = VSW + 1;

    vwm_state_e      state_q, state_d;
    vwm_op_e         op_q;
    logic [1:0]      esz_q;
    logic [4:0]      src_q, dst_q;
    logic [XLEN-1:0] base_q;
    logic [VSW-1:0]  vs_q;
    logic            illegal_q, fault_q;

    logic            cmd_ok;
    logic [1:0]      esz_eff;
    logic [TW-1:0]   len_new, len_q;
    logic            skip_new;
    logic            last_elem;
    logic            beat;
    logic            mem_err;
    logic [1:0]      grp_q;
    logic [XLEN-1:0] rd_addr, wr_addr;

    vwm_legal_chk #(.REGW(5)) u_legal (
        .op      (op),
        .grp     (grp),
        .src_reg (src_reg),
        .dst_reg (dst_reg),
        .ok      (cmd_ok)
    );

    vwm_locator #(.VLEN(VLEN), .XLEN(XLEN), .REGW(5)) u_src_loc (
        .flat_idx  (vs_q),
        .esz       (esz_q),
        .reg_base  (src_q),
        .addr_base (base_q),
        .reg_o     (rf_rd_reg),
        .pos_o     (rf_rd_idx),
        .addr_o    (rd_addr)
    );

    vwm_locator #(.VLEN(VLEN), .XLEN(XLEN), .REGW(5)) u_dst_loc (
        .flat_idx  (vs_q),
        .esz       (esz_q),
        .reg_base  (dst_q),
        .addr_base (base_q),
        .reg_o     (rf_wr_reg),
        .pos_o     (rf_wr_idx),
        .addr_o    (wr_addr)
    );

    // Transfer length for the incoming command and for the latched one
    always_comb begin
        esz_eff   = (vwm_op_e'(op) == OP_MOVE) ? 2'd0 : esz;
        len_new   = (TW'(VLENB) << grp) >> esz_eff;
        skip_new  = {1'b0, vs_q} >= len_new;
        len_q     = (TW'(VLENB) << grp_q) >> esz_q;
        last_elem = {1'b0, vs_q} == (len_q - TW'(1));
    end

    // State register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            op_q      <= OP_MOVE;
            grp_q     <= '0;
            esz_q     <= '0;
            src_q     <= '0;
            dst_q     <= '0;
            base_q    <= '0;
            vs_q      <= '0;
            illegal_q <= 1'b0;
            fault_q   <= 1'b0;
        end else begin
            state_q   <= state_d;
            illegal_q <= 1'b0;
            fault_q   <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        if (!cmd_ok) begin
                            illegal_q <= 1'b1;
                        end else begin
                            op_q   <= vwm_op_e'(op);
                            grp_q  <= grp;
                            esz_q  <= esz_eff;
                            src_q  <= src_reg;
                            dst_q  <= dst_reg;
                            base_q <= mem_base;
                        end
                    end else if (csr_wr) begin
                        vs_q <= csr_wdata[VSW-1:0];
                    end
                end
                ST_RUN: begin
                    if (mem_err) begin
                        fault_q <= 1'b1;
                    end else if (beat) begin
                        vs_q <= last_elem ? '0 : vs_q + VSW'(1);
                    end
                end
                ST_FIN: ;
                default: ;
            endcase
        end
    end

    // Outputs and next state
    always_comb begin
        state_d   = state_q;
        busy      = 1'b0;
        done      = 1'b0;
        rf_we     = 1'b0;
        rf_wdata  = rf_rdata;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = rd_addr;
        beat      = 1'b0;
        mem_err   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start && cmd_ok) begin
                    state_d = skip_new ? ST_FIN : ST_RUN;
                end
            end
            ST_RUN: begin
                busy = 1'b1;
                unique case (op_q)
                    OP_MOVE: begin
                        rf_we = 1'b1;
                        beat  = 1'b1;
                    end
                    OP_LOAD: begin
                        mem_req  = 1'b1;
                        mem_addr = wr_addr;
                        rf_wdata = mem_rdata;
                        mem_err  = mem_ready && mem_fault;
                        rf_we    = mem_ready && !mem_fault;
                        beat     = rf_we;
                    end
                    default: begin
                        mem_req = 1'b1;
                        mem_we  = 1'b1;
                        mem_err = mem_ready && mem_fault;
                        beat    = mem_ready && !mem_fault;
                    end
                endcase
                if (mem_err) begin
                    state_d = ST_IDLE;
                end else if (beat && last_elem) begin
                    state_d = ST_FIN;
                end
            end
            ST_FIN: begin
                done    = 1'b1;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign vstart    = vs_q;
    assign illegal   = illegal_q;
    assign fault     = fault_q;
    assign rf_esz    = esz_q;
    assign mem_wdata = rf_rdata;
endmodule

// File: rtl/vreg_whole_mover_chk.sv
module vreg_whole_mover_chk #(
    parameter int VLEN = 128,
    localparam int VSW = $clog2(VLEN)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           busy,
    input logic           done,
    input logic           illegal,
    input logic           fault,
    input logic [VSW-1:0] vstart,
    input logic           rf_we,
    input logic           mem_req,
    input logic           mem_we,
    input logic           mem_ready,
    input logic           mem_fault
);
    logic step;
    assign step = rf_we || (mem_req && mem_we && mem_ready && !mem_fault);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_not_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && busy));

    assert_reject_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!busy && !done && $stable(vstart)));

    assert_index_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> ((vstart == $past(vstart) + VSW'(1)) || (done && vstart == '0)));

    assert_fault_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready && mem_fault) |=> (fault && !busy && !done && $stable(vstart)));

    assert_access_in_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we || mem_req) |-> busy);
endmodule

bind vreg_whole_mover vreg_whole_mover_chk #(.VLEN(VLEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .illegal   (illegal),
    .fault     (fault),
    .vstart    (vstart),
    .rf_we     (rf_we),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ready (mem_ready),
    .mem_fault (mem_fault)
);

// File: tb/vreg_whole_mover_test.sv
module vreg_whole_mover_test;
    localparam int VLEN  = 128;
    localparam int XLEN  = 32;
    localparam int ELEN  = 64;
    localparam int VLENB = VLEN / 8;
    localparam int LVB   = $clog2(VLENB);
    localparam int VSW   = $clog2(VLEN);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            csr_wr = 1'b0;
    logic [XLEN-1:0] csr_wdata = '0;
    logic [VSW-1:0]  vstart;
    logic            start = 1'b0;
    logic [1:0]      op = '0, grp = '0, esz = '0;
    logic [4:0]      src_reg = '0, dst_reg = '0;
    logic [XLEN-1:0] mem_base = '0;
    logic            busy, done, illegal, fault;
    logic [4:0]      rf_rd_reg, rf_wr_reg;
    logic [LVB-1:0]  rf_rd_idx, rf_wr_idx;
    logic [ELEN-1:0] rf_rdata, rf_wdata, mem_wdata, mem_rdata;
    logic            rf_we, mem_req, mem_we, mem_ready, mem_fault;
    logic [1:0]      rf_esz;
    logic [XLEN-1:0] mem_addr;

    logic [7:0] rf_mem [32][VLENB];
    logic [7:0] ram [256];
    logic       slow_mode = 1'b0;
    logic       rdy_ph = 1'b0;
    logic       flt_en = 1'b0;
    logic [XLEN-1:0] flt_addr = '0;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    vreg_whole_mover #(.VLEN(VLEN), .XLEN(XLEN), .ELEN(ELEN)) uut (
        .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_wdata(csr_wdata), .vstart(vstart),
        .start(start), .op(op), .grp(grp), .esz(esz), .src_reg(src_reg), .dst_reg(dst_reg),
        .mem_base(mem_base), .busy(busy), .done(done), .illegal(illegal), .fault(fault),
        .rf_rd_reg(rf_rd_reg), .rf_rd_idx(rf_rd_idx), .rf_rdata(rf_rdata),
        .rf_we(rf_we), .rf_wr_reg(rf_wr_reg), .rf_wr_idx(rf_wr_idx), .rf_wdata(rf_wdata),
        .rf_esz(rf_esz), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .mem_fault(mem_fault)
    );

    // Register file and memory models
    always_comb begin
        rf_rdata = '0;
        for (int b = 0; b < 8; b++) begin
            if (b < (1 << rf_esz) && ((int'(rf_rd_idx) << rf_esz) + b) < VLENB)
                rf_rdata[b*8 +: 8] = rf_mem[rf_rd_reg][(int'(rf_rd_idx) << rf_esz) + b];
        end
        mem_rdata = '0;
        for (int b = 0; b < 8; b++) begin
            if (b < (1 << rf_esz))
                mem_rdata[b*8 +: 8] = ram[8'(mem_addr + XLEN'(b))];
        end
    end

    assign mem_ready = !slow_mode || rdy_ph;
    assign mem_fault = mem_req && flt_en && (mem_addr == flt_addr);

    always @(posedge clk) begin
        rdy_ph <= ~rdy_ph;
        if (rf_we) begin
            for (int b = 0; b < 8; b++)
                if (b < (1 << rf_esz))
                    rf_mem[rf_wr_reg][(int'(rf_wr_idx) << rf_esz) + b] <= rf_wdata[b*8 +: 8];
        end
        if (mem_req && mem_we && mem_ready && !mem_fault) begin
            for (int b = 0; b < 8; b++)
                if (b < (1 << rf_esz))
                    ram[8'(mem_addr + XLEN'(b))] <= mem_wdata[b*8 +: 8];
        end
    end

    function automatic logic [7:0] rpat(int r, int b);
        return 8'(r * 16 + b + 1);
    endfunction

    function automatic logic [7:0] mpat(int a);
        return 8'(a * 7 + 3);
    endfunction

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic fill_all();
        @(negedge clk);
        for (int r = 0; r < 32; r++)
            for (int b = 0; b < VLENB; b++)
                rf_mem[r][b] = rpat(r, b);
        for (int a = 0; a < 256; a++)
            ram[a] = mpat(a);
    endtask

    task automatic set_vstart(input logic [XLEN-1:0] v);
        @(negedge clk);
        csr_wr = 1'b1;
        csr_wdata = v;
        @(negedge clk);
        csr_wr = 1'b0;
    endtask

    // Issue a command; count rising edges until a pulse is seen
    task automatic run_op(input logic [1:0] o, g, e, input logic [4:0] s, d,
                          input logic [XLEN-1:0] b, input int csr_at,
                          output int n, output bit sd, output bit sf, output bit si);
        @(negedge clk);
        op = o; grp = g; esz = e; src_reg = s; dst_reg = d; mem_base = b;
        start = 1'b1;
        n = 0; sd = 0; sf = 0; si = 0;
        while (!(sd || sf || si) && n < 2000) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            start = 1'b0;
            csr_wr = 1'b0;
            if (n == csr_at) begin
                csr_wr = 1'b1;
                csr_wdata = 32'd9;
            end
            sd = done; sf = fault; si = illegal;
        end
        csr_wr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R9", "busy after reset", busy, 0);
        chk("R9", "done after reset", done, 0);
        chk("R5", "vstart after reset", vstart, 0);
    endtask

    task automatic t_csr_mask();
        set_vstart(32'hFFFF_FF85);
        chk("R1", "masked vstart", vstart, 5);
        set_vstart(32'h0000_0080);
        chk("R1", "masked vstart high bit", vstart, 0);
    endtask

    task automatic t_move_full();
        int n; bit sd, sf, si; int bad = 0;
        fill_all();
        set_vstart(0);
        run_op(2'b00, 2'd1, 2'd3, 5'd2, 5'd4, '0, -1, n, sd, sf, si);
        for (int k = 0; k < 2; k++)
            for (int b = 0; b < VLENB; b++)
                if (rf_mem[4+k][b] != rpat(2+k, b)) bad++;
        chk("R3", "move 2 regs bad bytes", bad, 0);
        chk("R7", "move 32 elems edges to done", n, 33);
        chk("R5", "vstart cleared", vstart, 0);
        chk("R5", "done seen", sd, 1);
    endtask

    task automatic t_move_resume();
        int n; bit sd, sf, si; int bad = 0;
        fill_all();
        set_vstart(5);
        run_op(2'b00, 2'd0, 2'd0, 5'd8, 5'd9, '0, -1, n, sd, sf, si);
        for (int b = 0; b < VLENB; b++)
            if (rf_mem[9][b] != (b < 5 ? rpat(9, b) : rpat(8, b))) bad++;
        chk("R5", "resumed move bad bytes", bad, 0);
        chk("R7", "resumed move edges", n, 12);
        chk("R5", "vstart cleared after resume", vstart, 0);
    endtask

    task automatic t_skip();
        int n; bit sd, sf, si; int bad = 0;
        fill_all();
        set_vstart(20);
        run_op(2'b00, 2'd0, 2'd0, 5'd10, 5'd11, '0, -1, n, sd, sf, si);
        for (int b = 0; b < VLENB; b++)
            if (rf_mem[11][b] != rpat(11, b)) bad++;
        chk("R4", "skip dst untouched", bad, 0);
        chk("R4", "skip vstart kept", vstart, 20);
        chk("R4", "skip done edges", n, 1);
        chk("R4", "skip done", sd, 1);
    endtask

    task automatic t_illegal();
        int n; bit sd, sf, si; int bad = 0;
        fill_all();
        set_vstart(3);
        run_op(2'b00, 2'd2, 2'd0, 5'd2, 5'd8, '0, -1, n, sd, sf, si);
        for (int k = 0; k < 4; k++)
            for (int b = 0; b < VLENB; b++)
                if (rf_mem[8+k][b] != rpat(8+k, b)) bad++;
        chk("R2", "misaligned illegal", si, 1);
        chk("R2", "misaligned edges", n, 1);
        chk("R2", "misaligned dst untouched", bad, 0);
        chk("R2", "misaligned vstart kept", vstart, 3);
        run_op(2'b11, 2'd0, 2'd0, 5'd0, 5'd1, '0, -1, n, sd, sf, si);
        chk("R2", "reserved op illegal", si, 1);
        run_op(2'b01, 2'd1, 2'd0, 5'd3, 5'd4, 32'd0, -1, n, sd, sf, si);
        chk("R2", "load ignores src alignment", sd, 1);
    endtask

    task automatic t_load_split();
        int n; bit sd, sf, si; int bad = 0;
        fill_all();
        slow_mode = 1'b1;
        set_vstart(3);
        run_op(2'b01, 2'd1, 2'd2, 5'd0, 5'd12, 32'd64, -1, n, sd, sf, si);
        slow_mode = 1'b0;
        for (int b = 0; b < VLENB; b++) begin
            if (rf_mem[12][b] != (b < 12 ? rpat(12, b) : mpat(64 + b))) bad++;
            if (rf_mem[13][b] != mpat(64 + 16 + b)) bad++;
        end
        chk("R6", "split load bad bytes", bad, 0);
        chk("R5", "split load done", sd, 1);
        chk("R5", "split load vstart", vstart, 0);
    endtask

    task automatic t_store_fault();
        int n; bit sd, sf, si; int bad = 0;
        fill_all();
        set_vstart(0);
        flt_en = 1'b1;
        flt_addr = 32'd135;
        run_op(2'b10, 2'd0, 2'd0, 5'd5, 5'd0, 32'd128, -1, n, sd, sf, si);
        flt_en = 1'b0;
        for (int a = 0; a < VLENB; a++)
            if (ram[128 + a] != (a < 7 ? rpat(5, a) : mpat(128 + a))) bad++;
        chk("R8", "fault seen", sf, 1);
        chk("R8", "no done on fault", sd, 0);
        chk("R8", "vstart at failing element", vstart, 7);
        chk("R8", "partial store bytes", bad, 0);
        run_op(2'b10, 2'd0, 2'd0, 5'd5, 5'd0, 32'd128, -1, n, sd, sf, si);
        bad = 0;
        for (int a = 0; a < VLENB; a++)
            if (ram[128 + a] != rpat(5, a)) bad++;
        chk("R8", "resumed store bytes", bad, 0);
        chk("R7", "resumed store edges", n, 10);
    endtask

    task automatic t_store_wide();
        int n; bit sd, sf, si; int bad = 0;
        fill_all();
        set_vstart(0);
        run_op(2'b10, 2'd0, 2'd3, 5'd6, 5'd0, 32'd0, -1, n, sd, sf, si);
        for (int a = 0; a < VLENB; a++)
            if (ram[a] != rpat(6, a)) bad++;
        chk("R3", "64-bit store bytes", bad, 0);
        chk("R3", "two elements edges", n, 3);
    endtask

    task automatic t_csr_busy();
        int n; bit sd, sf, si; int bad = 0;
        fill_all();
        set_vstart(0);
        run_op(2'b00, 2'd0, 2'd0, 5'd1, 5'd3, '0, 3, n, sd, sf, si);
        for (int b = 0; b < VLENB; b++)
            if (rf_mem[3][b] != rpat(1, b)) bad++;
        chk("R1", "write while busy ignored, bytes", bad, 0);
        chk("R1", "write while busy ignored, vstart", vstart, 0);
        chk("R1", "write while busy ignored, edges", n, 17);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_csr_mask();
        t_move_full();
        t_move_resume();
        t_skip();
        t_illegal();
        t_load_split();
        t_store_fault();
        t_store_wide();
        t_csr_busy();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule